// File: doc/BRIEF.md
# Asymmetric SCL Timing Generator

This block derives the clock waveform of a two-wire serial bus master from the system clock. A 32-bit divisor word is split into two halves. The lower half sets how long the bus clock stays low and the upper half sets how long it stays high. Each divisor unit stands for eight system clocks, so the bus clock frequency is the system clock divided by eight times the sum of the two halves. Software normally writes the same value into both halves, chosen as ceil(ceil(fclk/(8·fscl))/2). The usual target is 100 kHz, and 400 kHz is the highest valid rate.

Beside the clock level request, the block gives the master sequencer two single-cycle strobes. The change strobe marks the middle of each low phase, where the data line may be driven to a new value. The sample strobe marks the middle of each high phase, where the data line is read. The sequencer holds the run input high while a transfer is in progress. When run drops, the clock is parked high, the counters restart and no strobes are issued. A new divisor word is picked up only at the edge that opens a low phase, so a period never mixes old and new lengths.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and in every cycle in which run_i is low, scl_o is 1 and both strobes are 0.
- R2: When run_i is sampled high by a clock edge while the block is idle, scl_o is 0 from that edge on. This is the first cycle of a low phase.
- R3: A low phase lasts exactly 8·L system clock cycles, where L is divisor_i[15:0] as captured for that period.
- R4: A high phase lasts exactly 8·H system clock cycles, where H is divisor_i[31:16] as captured for that period. A high phase is followed at once by the next low phase.
- R5: A half value of 0 behaves exactly as a value of 1, giving a phase of 8 cycles.
- R6: chg_stb_o is 1 for exactly one cycle in each low phase, in cycle 4·L counted from 0 at the first low cycle. It is never 1 while scl_o is 1.
- R7: smp_stb_o is 1 for exactly one cycle in each high phase, in cycle 4·H counted from 0 at the first high cycle. It is never 1 while scl_o is 0.
- R8: divisor_i is captured only on the clock edge that opens a low phase. A change made in the middle of a period does not alter that period, and it applies from the next low phase on.
- R9: Dropping run_i restarts the counters. When run_i is raised again, the block begins a full-length low phase regardless of where it was stopped.
- R10: The phase counter never exceeds the length of the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | High to generate clock periods, low to park the clock high |
| divisor_i | input | 32 | [15:0] low-phase units, [31:16] high-phase units, 8 clocks per unit |
| scl_o | output | 1 | Requested bus clock level |
| chg_stb_o | output | 1 | Data-change strobe at the middle of the low phase |
| smp_stb_o | output | 1 | Data-sample strobe at the middle of the high phase |

## Verification
The waveform is measured one period at a time: the low length, the high length and the position and count of each strobe. Directed words cover equal halves, strongly unequal halves, halves of one and halves of zero. The zero case separates correct clamping from a zero-length phase. Randomly chosen halves from 0 to 20 catch mistakes that depend on the value, such as swapped halves or a wrong midpoint. A divisor change made during a low phase shows whether capture happens only at the period boundary. Stopping in mid-period and restarting shows whether the counters are really cleared.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  function automatic int unsigned cnt_width(int unsigned divw, int unsigned prescale);
    return divw + $clog2(prescale);
  endfunction
endpackage

// File: rtl/scl_div_capture.sv
module scl_div_capture #(
  parameter int unsigned DIVW     = 16,
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned CNTW     = DIVW + 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [2*DIVW-1:0]         divisor_i,
  output logic [1:0][CNTW-1:0]      len_o
);
  localparam logic [CNTW-1:0] PRE_C = CNTW'(PRESCALE);

  // index 0 = low half, index 1 = high half (matches phase encoding)
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [DIVW-1:0] raw;
    logic [DIVW-1:0] eff;
    assign raw = divisor_i[g*DIVW +: DIVW];
    assign eff = (raw == '0) ? DIVW'(1) : raw;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_o[g] <= PRE_C;
      end else if (load_i) begin
        len_o[g] <= PRE_C * {{(CNTW-DIVW){1'b0}}, eff};
      end
    end
  end

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(len_o)) else $error("length changed without load"); // R8
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (len_o[0] != '0) && (len_o[1] != '0)) else $error("zero phase length"); // R5
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_tgen_pkg::*;
#(
  parameter int unsigned CNTW = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic [1:0][CNTW-1:0]  len_i,
  output logic                  active_o,
  output phase_e                phase_o,
  output logic [CNTW-1:0]       cnt_o,
  output logic                  load_o
);
  logic [CNTW-1:0] last;
  logic            at_end;

  assign last   = len_i[phase_o] - CNTW'(1);
  assign at_end = (cnt_o == last);
  assign load_o = run_i && (!active_o || (phase_o == PH_HIGH && at_end));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      active_o <= 1'b0;
      phase_o  <= PH_LOW;
      cnt_o    <= '0;
    end else if (!active_o) begin
      active_o <= 1'b1;
      phase_o  <= PH_LOW;
      cnt_o    <= '0;
    end else if (at_end) begin
      cnt_o    <= '0;
      phase_o  <= (phase_o == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_o    <= cnt_o + CNTW'(1);
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!active_o && cnt_o == '0)) else $error("counter not cleared"); // R9
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !active_o) |=> (active_o && phase_o == PH_LOW && cnt_o == '0)) else $error("bad start"); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (cnt_o < len_i[phase_o])) else $error("counter overflow"); // R10
endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec
  import scl_tgen_pkg::*;
#(
  parameter int unsigned CNTW = 19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  active_i,
  input  phase_e                phase_i,
  input  logic [CNTW-1:0]       cnt_i,
  input  logic [1:0][CNTW-1:0]  len_i,
  output logic                  scl_o,
  output logic                  chg_o,
  output logic                  smp_o
);
  logic            live;
  logic [CNTW-1:0] mid;

  assign live  = run_i && active_i;
  assign mid   = len_i[phase_i] >> 1;
  assign scl_o = !(live && phase_i == PH_LOW);
  assign chg_o = live && phase_i == PH_LOW  && cnt_i == mid;
  assign smp_o = live && phase_i == PH_HIGH && cnt_i == mid;

  AST_CHG_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> !scl_o) else $error("change strobe while high"); // R6
  AST_SMP_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |-> scl_o) else $error("sample strobe while low"); // R7
  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |=> !chg_o) else $error("change strobe held"); // R6
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int unsigned DIVW     = 16,
  parameter int unsigned PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [2*DIVW-1:0] divisor_i,
  output logic              scl_o,
  output logic              chg_stb_o,
  output logic              smp_stb_o
);
  localparam int unsigned CNTW = cnt_width(DIVW, PRESCALE);

  logic [1:0][CNTW-1:0] len;
  logic                 active;
  phase_e               phase;
  logic [CNTW-1:0]      cnt;
  logic                 load;

  scl_div_capture #(.DIVW(DIVW), .PRESCALE(PRESCALE), .CNTW(CNTW)) u_cap (
    .clk(clk), .rst_n(rst_n), .load_i(load), .divisor_i(divisor_i), .len_o(len)
  );

  scl_phase_seq #(.CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .len_i(len),
    .active_o(active), .phase_o(phase), .cnt_o(cnt), .load_o(load)
  );

  scl_strobe_dec #(.CNTW(CNTW)) u_dec (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .active_i(active), .phase_i(phase),
    .cnt_i(cnt), .len_i(len), .scl_o(scl_o), .chg_o(chg_stb_o), .smp_o(smp_stb_o)
  );

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (scl_o && !chg_stb_o && !smp_stb_o)) else $error("not parked"); // R1
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb_o && smp_stb_o)) else $error("both strobes"); // R6
endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [31:0] divisor_i = 32'h0001_0001;
  logic        scl_o, chg_stb_o, smp_stb_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .divisor_i(divisor_i),
    .scl_o(scl_o), .chg_stb_o(chg_stb_o), .smp_stb_o(smp_stb_o)
  );

  function automatic int eff(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Precondition: current sample is the first low cycle of a period.
  task automatic measure(output int lowc, output int chg_at, output int chg_n,
                         output int highc, output int smp_at, output int smp_n,
                         output int bad);
    lowc = 0; highc = 0; chg_at = -1; smp_at = -1; chg_n = 0; smp_n = 0; bad = 0;
    while (scl_o == 1'b0 && lowc < 600000) begin
      if (chg_stb_o) begin chg_n++; chg_at = lowc; end
      if (smp_stb_o) bad++;
      lowc++;
      step();
    end
    while (scl_o == 1'b1 && highc < 600000) begin
      if (smp_stb_o) begin smp_n++; smp_at = highc; end
      if (chg_stb_o) bad++;
      highc++;
      step();
    end
  endtask

  task automatic check_period(input string what, input int l, input int h);
    int lc, ca, cn, hc, sa, sn, bd;
    measure(lc, ca, cn, hc, sa, sn, bd);
    check({"R3 low length ", what}, lc, 8 * eff(l));
    check({"R4 high length ", what}, hc, 8 * eff(h));
    check({"R6 change position ", what}, ca, 4 * eff(l));
    check({"R6 change count ", what}, cn, 1);
    check({"R7 sample position ", what}, sa, 4 * eff(h));
    check({"R7 sample count ", what}, sn, 1);
    check({"R6 R7 strobe in wrong phase ", what}, bd, 0);
  endtask

  task automatic start_run(input int l, input int h);
    @(negedge clk);
    divisor_i = {16'(h), 16'(l)};
    run_i = 1'b1;
    step();
    check("R2 low right after start", int'(scl_o), 0);
  endtask

  task automatic stop_run();
    @(negedge clk);
    run_i = 1'b0;
    #1;
    check("R1 parked high at stop", int'(scl_o), 1);
    for (int i = 0; i < 20; i++) begin
      if (scl_o !== 1'b1 || chg_stb_o !== 1'b0 || smp_stb_o !== 1'b0) begin
        check("R1 idle quiet", 1, 0);
      end
      step();
    end
  endtask

  task automatic run_pair(input string what, input int l, input int h);
    start_run(l, h);
    check_period(what, l, h);
    check_period(what, l, h);
    stop_run();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lc, ca, cn, hc, sa, sn, bd;
    void'($urandom(32'd4711));
    repeat (3) step();
    check("R1 reset scl", int'(scl_o), 1);
    check("R1 reset strobes", int'(chg_stb_o | smp_stb_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 idle scl", int'(scl_o), 1);

    run_pair("equal 5/5", 5, 5);
    run_pair("unequal 3/7", 3, 7);
    run_pair("unequal 9/2", 9, 2);
    run_pair("unit 1/1", 1, 1);
    run_pair("R5 zero 0/0", 0, 0);
    run_pair("R5 zero low 0/4", 0, 4);
    run_pair("long 300/5", 300, 5);

    // R8: change divisor during the low phase of the first period
    start_run(4, 6);
    fork
      measure(lc, ca, cn, hc, sa, sn, bd);
      begin
        repeat (3) @(negedge clk);
        divisor_i = {16'd2, 16'd3};
      end
    join
    check("R8 old low kept", lc, 32);
    check("R8 old high kept", hc, 48);
    check_period("R8 new word applied", 3, 2);
    stop_run();

    // R9: stop in mid high phase, restart gives full low phase
    start_run(6, 6);
    repeat (70) step();
    stop_run();
    start_run(6, 6);
    check_period("R9 after restart", 6, 6);
    stop_run();

    for (int k = 0; k < 16; k++) begin
      int l, h;
      l = int'($urandom_range(0, 20));
      h = int'($urandom_range(0, 20));
      run_pair($sformatf("random %0d/%0d", l, h), l, h);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule